// File: doc/BRIEF.md
# Parallel FIFO with Read Rewind

This block is a first-in first-out buffer, 1024 words deep and 9 bits wide, so that a parity bit can travel with each data byte. It keeps its own addresses: a write pointer and a read pointer each step forward by one for every accepted write or read strobe. The caller supplies no address. Both strobes are single-cycle enables sampled on one system clock, and a write and a read may be accepted in the same cycle.

An occupancy level drives three status flags: empty, full and half-full. A full buffer refuses writes and an empty buffer refuses reads, so data can neither overflow nor underflow. A rewind input sends the read pointer back to location zero. It leaves the write pointer and the stored words alone, so that everything written since reset can be read out again after an error downstream.

Top module: `rtx_fifo`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `empty` is 1, `full` and `half_full` are 0 and `rd_data` is 0.
- R2: Words are read out in the order they were written. An accepted read puts its word on `rd_data` in the cycle after the strobe, and `rd_data` then holds until the next accepted read.
- R3: `full` is 1 exactly when DEPTH words are held. A write strobe while full, with no read in the same cycle, is refused and changes neither the stored words nor the flags.
- R4: `empty` is 1 exactly when no word is held. A read strobe while empty is refused and leaves `rd_data` and the flags unchanged.
- R5: `half_full` is 1 exactly when at least DEPTH/2 words are held.
- R6: While full, a write and a read in the same cycle are both accepted. The buffer stays full, and the word read out is the oldest one held, not the word being written.
- R7: While empty, a write and a read in the same cycle accept the write and refuse the read. `empty` falls in the next cycle and `rd_data` is unchanged.
- R8: A cycle with `rewind_req` high sets the read pointer to zero and the level to the number of words written since reset. The following reads replay the words from the first one written, and later writes append after the last word written. This holds only while fewer than DEPTH words have been written since reset.
- R9: A read strobe in the same cycle as `rewind_req` is ignored: `rd_data` does not change and the replay still starts at the first word. A write strobe in that cycle is still accepted.
- R10: When a write and a read are both accepted in a cycle where the buffer is neither empty nor full, the level is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read strobe, one word per cycle |
| rewind_req | input | 1 | Send the read pointer back to location zero |
| rd_data | output | WIDTH | Last word read, registered |
| empty | output | 1 | No word held |
| full | output | 1 | DEPTH words held |
| half_full | output | 1 | At least DEPTH/2 words held |

## Verification
The bench builds the block with DEPTH set to 16 and WIDTH to 9. At that depth the full boundary, the half-full threshold of 8 and the refused write on a full buffer are all reached within a few dozen strobes, and the ninth data bit is exercised. The small depth also lets a rewind test write and replay a run shorter than DEPTH, and append to it, without running into the wrap limit that R8 sets. Simultaneous strobes are driven at the empty, full and intermediate levels.

// File: rtl/rtx_fifo_pkg.sv
package rtx_fifo_pkg;

  // Pointer position after an optional one-step advance, wrapping at depth.
  function automatic int unsigned ptr_after(int unsigned p, logic adv, int unsigned depth);
    if (!adv) return p;
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle of accepted pushes and pops.
  function automatic int unsigned level_after(int unsigned lvl, logic inc, logic dec);
    return lvl + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

  // Level reloaded by a rewind: words written so far, including this cycle's.
  function automatic int unsigned level_on_rewind(int unsigned wpos, logic inc);
    return wpos + (inc ? 1 : 0);
  endfunction

  // Half-full threshold test.
  function automatic bit at_half(int unsigned lvl, int unsigned depth);
    return lvl >= depth / 2;
  endfunction

endpackage

// File: rtl/rtx_fifo_ptr.sv
module rtx_fifo_ptr #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          clear,
  output logic [AW-1:0] ptr
);
  import rtx_fifo_pkg::*;

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (clear)  ptr_q <= '0;
    else             ptr_q <= AW'(ptr_after(32'(ptr_q), step, DEPTH));
  end

  assign ptr = ptr_q;

  // R8: a clear request lands the pointer on location zero
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ptr_q == '0));

  // R2: every accepted strobe moves the pointer
  p_step_moves_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clear && DEPTH > 1) |=> (ptr_q != $past(ptr_q)));

  // R4: with no strobe and no clear the pointer holds
  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clear) |=> $stable(ptr_q));

endmodule

// File: rtl/rtx_fifo_store.sv
module rtx_fifo_store #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Old contents are read when both ports hit one address in a cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end

  // R2: the output register changes only after an accepted read
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata));

endmodule

// File: rtl/rtx_fifo_level.sv
module rtx_fifo_level #(
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          rewind,
  input  logic [AW-1:0] wr_pos,
  output logic          empty,
  output logic          full,
  output logic          half
);
  import rtx_fifo_pkg::*;

  logic [CW-1:0] level_q;
  logic [CW-1:0] level_d;

  always_comb begin
    if (rewind) level_d = CW'(level_on_rewind(32'(wr_pos), inc));
    else        level_d = CW'(level_after(32'(level_q), inc, dec));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign empty = (level_q == '0);
  assign full  = (level_q == CW'(DEPTH));
  assign half  = at_half(32'(level_q), DEPTH);

  // R3: the level never leaves 0..DEPTH
  p_level_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CW'(DEPTH));

  // R10: a balanced push and pop leaves the level alone
  p_balanced_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec && !rewind) |=> $stable(level_q));

  // R4: a pop is never applied to an empty buffer
  p_no_pop_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec && empty));

endmodule

// File: rtl/rtx_fifo.sv
module rtx_fifo #(
  parameter int DEPTH = 1024,
  parameter int WIDTH = 9,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic             rewind_req,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic             half_full
);
  // Named internal events, visible to the assertions below.
  logic          rd_fire;
  logic          wr_fire;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  assign rd_fire = rd_en && !rewind_req && !empty;
  assign wr_fire = wr_en && (!full || rd_fire);

  rtx_fifo_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk(clk), .rst_n(rst_n), .step(wr_fire), .clear(1'b0), .ptr(wr_ptr));

  rtx_fifo_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk(clk), .rst_n(rst_n), .step(rd_fire), .clear(rewind_req), .ptr(rd_ptr));

  rtx_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(wr_fire), .waddr(wr_ptr), .wdata(wr_data),
    .re(rd_fire), .raddr(rd_ptr), .rdata(rd_data));

  rtx_fifo_level #(.DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_n), .inc(wr_fire), .dec(rd_fire),
    .rewind(rewind_req), .wr_pos(wr_ptr),
    .empty(empty), .full(full), .half(half_full));

  // R3: a lone write into a full buffer leaves it full
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !rewind_req) |=> full);

  // R4: a lone read from an empty buffer changes nothing visible
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en && !rewind_req) |=> (empty && $stable(rd_data)));

  // R6: simultaneous strobes on a full buffer keep it full
  p_full_both_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && rd_en && !rewind_req) |=> full);

  // R7: a write into an empty buffer always lands
  p_empty_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && wr_en && !rewind_req) |=> (!empty && $stable(rd_data)));

  // R9: a read strobe during rewind leaves the output register alone
  p_rewind_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_req |=> $stable(rd_data));

  // R5: full implies half-full, and the end flags exclude each other
  p_flags_sane_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty) && (!full || half_full));

endmodule

// File: tb/rtx_fifo_tb_top.sv
module rtx_fifo_tb_top;
  localparam int D = 16;
  localparam int W = 9;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic         rd_en = 1'b0;
  logic         rewind_req = 1'b0;
  logic [W-1:0] rd_data;
  logic         empty, full, half_full;

  always #5 clk = ~clk;

  rtx_fifo #(.DEPTH(D), .WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rewind_req(rewind_req), .rd_data(rd_data),
    .empty(empty), .full(full), .half_full(half_full));

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference model: every word written since reset, and the read index.
  logic [W-1:0] hist[$];
  int           rd_idx = 0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] last_rd = '0;
  bit           pend = 0;
  string        ptag = "";

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard one step after each accepted read.
  always begin
    @(posedge clk);
    #1;
    if (pend) begin
      if (exp_q.size() == 0) begin
        chk(0, ptag, "scoreboard empty", 0, 1);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, ptag, "rd_data", int'(rd_data), int'(e));
        last_rd = e;
      end
    end
  end

  task automatic check_flags(string tag);
    int cnt;
    cnt = hist.size() - rd_idx;
    chk(empty == (cnt == 0), tag, "empty", int'(empty), int'(cnt == 0));
    chk(full == (cnt == D), tag, "full", int'(full), int'(cnt == D));
    chk(half_full == (cnt >= D / 2), tag, "half_full", int'(half_full), int'(cnt >= D / 2));
  endtask

  // Driver: one cycle of strobes, starting and ending at a falling edge.
  task automatic step(bit w, logic [W-1:0] d, bit r, bit t, string tag);
    int cnt;
    bit ra, wa;
    cnt = hist.size() - rd_idx;
    ra = r && !t && cnt > 0;
    wa = w && (cnt < D || ra);
    wr_en = w; wr_data = d; rd_en = r; rewind_req = t;
    if (ra) exp_q.push_back(hist[rd_idx]);
    pend = ra; ptag = tag;
    @(posedge clk);
    @(negedge clk);
    if (ra) rd_idx++;
    if (wa) hist.push_back(d);
    if (t) rd_idx = 0;
    wr_en = 0; rd_en = 0; rewind_req = 0; pend = 0;
    check_flags(tag);
    if (!ra) chk(rd_data == last_rd, tag, "rd_data held", int'(rd_data), int'(last_rd));
  endtask

  task automatic do_reset();
    rst_n = 0; wr_en = 0; rd_en = 0; rewind_req = 0;
    @(negedge clk);
    chk(empty && !full && !half_full && rd_data == '0, "R1", "flags/data in reset",
        int'({empty, full, half_full}), 4);
    @(negedge clk);
    rst_n = 1;
    hist.delete(); exp_q.delete(); rd_idx = 0; last_rd = '0;
    @(negedge clk);
    chk(rd_data == '0, "R1", "rd_data after reset", int'(rd_data), 0);
    check_flags("R1");
  endtask

  initial begin
    do_reset();
    // R4: read on empty
    step(0, '0, 1, 0, "R4");
    // R2: ordered transfer with the ninth bit set
    for (int i = 0; i < 5; i++) step(1, W'(9'h1A0 + i), 0, 0, "R2");
    for (int i = 0; i < 5; i++) step(0, '0, 1, 0, "R2");
    step(0, '0, 1, 0, "R4");
    // R5 / R3: fill to the top, crossing the half threshold
    for (int i = 0; i < D; i++) step(1, W'(9'h100 + i * 3), 0, 0, "R5");
    step(1, W'(9'h0FF), 0, 0, "R3");
    step(1, W'(9'h0FE), 0, 0, "R3");
    // R6: simultaneous strobes while full
    for (int i = 0; i < 3; i++) step(1, W'(9'h0C0 + i), 1, 0, "R6");
    // R3: drain, proving the refused writes left no trace
    for (int i = 0; i < D; i++) step(0, '0, 1, 0, "R3");
    // R7: simultaneous strobes while empty
    step(1, W'(9'h055), 1, 0, "R7");
    step(0, '0, 1, 0, "R7");
    // R10: balanced traffic at an intermediate level
    for (int i = 0; i < 4; i++) step(1, W'(9'h020 + i), 0, 0, "R10");
    for (int i = 0; i < 6; i++) step(1, W'(9'h130 + i), 1, 0, "R10");
    for (int i = 0; i < 4; i++) step(0, '0, 1, 0, "R10");
    // R8: rewind replays from the first word and appends after the last
    do_reset();
    for (int i = 0; i < 6; i++) step(1, W'(9'h140 + i), 0, 0, "R8");
    for (int i = 0; i < 3; i++) step(0, '0, 1, 0, "R8");
    step(0, '0, 0, 1, "R8");
    for (int i = 0; i < 6; i++) step(0, '0, 1, 0, "R8");
    for (int i = 0; i < 2; i++) step(1, W'(9'h0A0 + i), 0, 0, "R8");
    for (int i = 0; i < 2; i++) step(0, '0, 1, 0, "R8");
    // R9: read ignored during rewind, write still accepted
    step(1, W'(9'h1EE), 1, 1, "R9");
    step(0, '0, 1, 0, "R9");
    for (int i = 0; i < 8; i++) step(0, '0, 1, 0, "R9");
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule